// File: doc/BRIEF.md
# Processor Status Word Update Unit

This block holds the 16-bit processor status word of a small CPU core and applies, one per clock, the status changes made by the core's zero-group operations. The execute stage selects an operation and supplies the instruction word. The unit can set or clear condition flags under a mask taken from the instruction. It can write a new interrupt priority level, which only happens in kernel mode. It can byte-swap an operand, register the swapped value and derive the flags from it. It can also replace the whole status word with a word the core has popped from the stack during a return from interrupt or trap.

The current mode is read from the status word itself, so the unit decides on its own whether a priority write is allowed. A reload arrives on its own valid strobe, separate from the operation select. When both are present in the same cycle, the reload wins.

Top module: `psw_update_unit`

## Requirements
- R1: A synchronous active-high reset clears the status word and the swap-result register to zero: kernel mode, priority 0, all flags clear.
- R2: With `op_sel` = 01 (condition-code op), each flag whose enable bit is 1 is written with `instr[4]` (1 = set, 0 = clear). The enable bits are `instr[3]` for N (status bit 3), `instr[2]` for Z (bit 2), `instr[1]` for V (bit 1) and `instr[0]` for C (bit 0). Flags that are not enabled, and status bits 15:4, keep their values.
- R3: With `op_sel` = 10 (priority set) in kernel mode (status bits 15:14 = 00), status bits 7:5 take `instr[2:0]` one clock later and every other bit keeps its value.
- R4: With `op_sel` = 10 outside kernel mode (status bits 15:14 not 00), the status word does not change.
- R5: With `op_sel` = 11 (byte swap), `swab_result` shows the operand with its upper and lower bytes exchanged one clock later. In all other cycles it holds its value.
- R6: After a byte swap, N (bit 3) equals bit 7 of the swapped result, Z (bit 2) is 1 exactly when the swapped result's low byte is zero, V and C are cleared, and status bits 15:4 keep their values.
- R7: When `rld_valid` is 1, the whole status word is replaced by `rld_word` one clock later.
- R8: A reload takes priority over any flag or priority update selected in the same cycle. The byte-swap result register still captures a swap selected in that cycle.
- R9: With `op_sel` = 00 and no reload, the status word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | Operation: 00 idle, 01 condition codes, 10 priority set, 11 byte swap |
| instr | input | 16 | Instruction word carrying mask, set/clear bit and priority level |
| swab_operand | input | 16 | Operand for the byte swap |
| rld_valid | input | 1 | Reload the status word this cycle |
| rld_word | input | 16 | Popped status word used for the reload |
| psw | output | 16 | Current processor status word |
| swab_result | output | 16 | Registered byte-swapped value |

## Verification
A wrong internal state shows up in `psw` in the cycle right after the faulty update, because every change is a single registered step. An error in the mode bits is less direct. It only becomes visible when a later priority-set is wrongly accepted or dropped, so the bench puts priority-set operations right after reloads that switch between kernel and user mode. A swap whose flags are taken from the wrong byte shows up as a flag mismatch on the very next clock. The bench therefore uses operands whose upper and lower bytes give different N and Z.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int FLAG_N   = 4;
    localparam int FLAG_LO  = 0;
    localparam int BIT_C    = 0;
    localparam int BIT_V    = 1;
    localparam int BIT_Z    = 2;
    localparam int BIT_N    = 3;
    localparam int PRI_LO   = 5;
    localparam int PRI_W    = 3;
    localparam int MODE_LO  = 14;
    localparam int MODE_W   = 2;
    localparam int SETCLR_B = 4;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_CC   = 2'b01,
        OP_SPL  = 2'b10,
        OP_SWAB = 2'b11
    } psw_op_e;

    typedef struct packed {
        logic [PSW_W-1:0] psw;
        logic [PSW_W-1:0] swab;
    } psw_state_t;

endpackage

// File: rtl/psw_cc_unit.sv
module psw_cc_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = PSW_W,
    parameter int NFLAGS = FLAG_N
) (
    input  logic [DATA_W-1:0] psw_in,
    input  logic              set_val,
    input  logic [NFLAGS-1:0] flag_en,
    output logic [DATA_W-1:0] psw_out
);
    localparam int HI_LO = FLAG_LO + NFLAGS;

    logic [NFLAGS-1:0] flags_d;

    // one mux per flag: enabled flags take the set/clear value
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        always_comb begin
            flags_d[g] = flag_en[g] ? set_val : psw_in[FLAG_LO + g];
        end
    end

    always_comb begin
        psw_out = psw_in;
        psw_out[HI_LO-1:FLAG_LO] = flags_d;
    end
endmodule

// File: rtl/psw_spl_unit.sv
module psw_spl_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = PSW_W,
    parameter int LVL_W  = PRI_W
) (
    input  logic [DATA_W-1:0] psw_in,
    input  logic              kernel,
    input  logic [LVL_W-1:0]  level,
    output logic [DATA_W-1:0] psw_out
);
    always_comb begin
        psw_out = psw_in;
        if (kernel) begin
            psw_out[PRI_LO +: LVL_W] = level;
        end
    end
endmodule

// File: rtl/psw_swab_unit.sv
module psw_swab_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = PSW_W,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] psw_in,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] psw_out
);
    always_comb begin
        result  = {operand[HALF_W-1:0], operand[DATA_W-1:HALF_W]};
        psw_out = psw_in;
        // flags follow the low byte of the swapped value only
        psw_out[BIT_N] = result[HALF_W-1];
        psw_out[BIT_Z] = (result[HALF_W-1:0] == '0);
        psw_out[BIT_V] = 1'b0;
        psw_out[BIT_C] = 1'b0;
    end
endmodule

// File: rtl/psw_update_unit.sv
module psw_update_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = PSW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] swab_operand,
    input  logic              rld_valid,
    input  logic [DATA_W-1:0] rld_word,
    output logic [DATA_W-1:0] psw,
    output logic [DATA_W-1:0] swab_result
);
    localparam int HALF_W = DATA_W / 2;

    psw_state_t state_d, state_q;
    psw_op_e    op;
    logic       kernel;
    logic [DATA_W-1:0] psw_cc, psw_spl, psw_sw, sw_res;

    assign op     = psw_op_e'(op_sel);
    assign kernel = (state_q.psw[MODE_LO +: MODE_W] == '0);

    psw_cc_unit #(.DATA_W(DATA_W), .NFLAGS(FLAG_N)) u_cc (
        .psw_in  (state_q.psw),
        .set_val (instr[SETCLR_B]),
        .flag_en (instr[FLAG_N-1:0]),
        .psw_out (psw_cc)
    );

    psw_spl_unit #(.DATA_W(DATA_W), .LVL_W(PRI_W)) u_spl (
        .psw_in  (state_q.psw),
        .kernel  (kernel),
        .level   (instr[PRI_W-1:0]),
        .psw_out (psw_spl)
    );

    psw_swab_unit #(.DATA_W(DATA_W)) u_swab (
        .psw_in  (state_q.psw),
        .operand (swab_operand),
        .result  (sw_res),
        .psw_out (psw_sw)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CC:   state_d.psw = psw_cc;
            OP_SPL:  state_d.psw = psw_spl;
            OP_SWAB: begin
                state_d.psw  = psw_sw;
                state_d.swab = sw_res;
            end
            default: state_d.psw = state_q.psw;
        endcase
        // reload overrides any same-cycle flag or priority change
        if (rld_valid) begin
            state_d.psw = rld_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign psw         = state_q.psw;
    assign swab_result = state_q.swab;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (psw == '0 && swab_result == '0)); // R1
    AST_CC_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b01 && !rld_valid) |=> psw[DATA_W-1:FLAG_N] == $past(psw[DATA_W-1:FLAG_N])); // R2
    AST_SPL_USER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b10 && !rld_valid && psw[MODE_LO +: MODE_W] != '0) |=> $stable(psw)); // R4
    AST_SPL_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b10 && !rld_valid && psw[MODE_LO +: MODE_W] == '0)
        |=> psw[PRI_LO +: PRI_W] == $past(instr[PRI_W-1:0])); // R3
    AST_SWAB_SWAP: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11) |=> swab_result == {$past(swab_operand[HALF_W-1:0]), $past(swab_operand[DATA_W-1:HALF_W])}); // R5
    AST_SWAB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_sel != 2'b11) |=> $stable(swab_result)); // R5
    AST_SWAB_VC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11 && !rld_valid) |=> (psw[BIT_V] == 1'b0 && psw[BIT_C] == 1'b0)); // R6
    AST_RELOAD_WORD: assert property (@(posedge clk) disable iff (rst)
        rld_valid |=> psw == $past(rld_word)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b00 && !rld_valid) |=> $stable(psw)); // R9
endmodule

// File: tb/psw_update_unit_tb.sv
module psw_update_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op_sel;
    logic [15:0] instr, swab_operand, rld_word;
    logic        rld_valid;
    logic [15:0] psw, swab_result;

    int n_checks = 0;
    int n_errors = 0;
    int exp_psw  = 0;
    int exp_swab = 0;
    bit done = 0;

    always #2 clk = ~clk;

    psw_update_unit u_dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .instr(instr),
        .swab_operand(swab_operand), .rld_valid(rld_valid), .rld_word(rld_word),
        .psw(psw), .swab_result(swab_result)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%04h expected=%04h", tag, act, exp);
        end
    endtask

    // behavioural reference: next value from the requirement text
    task automatic model(input int op, input int ins, input int opnd,
                         input bit rv, input int rw);
        int np, ns, lo, hi;
        np = exp_psw;
        ns = exp_swab;
        if (op == 1) begin
            for (int b = 0; b < 4; b++)
                if ((ins >> b) & 1) begin
                    if ((ins >> 4) & 1) np = np | (1 << b);
                    else                np = np & ~(1 << b);
                end
        end else if (op == 2) begin
            if (((exp_psw >> 14) & 3) == 0)
                np = (np & ~(7 << 5)) | ((ins & 7) << 5);
        end else if (op == 3) begin
            lo = (opnd >> 8) & 255;
            hi = opnd & 255;
            ns = (hi << 8) | lo;
            np = np & ~15;
            if ((lo >> 7) & 1) np = np | 8;
            if (lo == 0)       np = np | 4;
        end
        if (rv) np = rw & 16'hffff;
        exp_psw  = np;
        exp_swab = ns;
    endtask

    task automatic step(string tag, input int op, input int ins, input int opnd,
                        input bit rv = 0, input int rw = 0);
        @(negedge clk);
        op_sel = op[1:0]; instr = ins[15:0]; swab_operand = opnd[15:0];
        rld_valid = rv; rld_word = rw[15:0];
        model(op, ins, opnd, rv, rw);
        @(posedge clk); #1;
        check({tag, " psw"}, int'(psw), exp_psw);
        check({tag, " swab"}, int'(swab_result), exp_swab);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; op_sel = 0; instr = 0; swab_operand = 0; rld_valid = 0; rld_word = 0;
        @(negedge clk); rld_valid = 1; rld_word = 16'hffff; op_sel = 3; swab_operand = 16'h1234;
        @(negedge clk); rld_valid = 0; op_sel = 0;
        @(posedge clk); #1;
        rst = 0;
        check("R1 reset psw", int'(psw), 0);
        check("R1 reset swab", int'(swab_result), 0);

        step("R2 set all", 1, 16'o277, 0);
        step("R2 clear Z,C", 1, 16'o245, 0);
        step("R2 set V only", 1, 16'o262, 0);
        step("R2 empty mask", 1, 16'o260, 0);
        step("R3 spl 5", 2, 16'o235, 0);
        step("R3 spl 0", 2, 16'o230, 0);
        step("R3 spl 7", 2, 16'o237, 0);
        step("R9 idle", 0, 16'hffff, 16'hffff);
        step("R5 R6 swab neg", 3, 16'o300, 16'h8000);
        step("R6 swab zero low", 3, 16'o300, 16'h00ff);
        step("R6 swab pos", 3, 16'o300, 16'h4100);
        step("R5 hold", 1, 16'o277, 16'h5555);
        step("R7 reload user", 0, 0, 0, 1, 16'hc0a5);
        step("R4 spl user", 2, 16'o233, 0);
        step("R2 cc in user", 1, 16'o241, 0);
        step("R7 reload prev", 0, 0, 0, 1, 16'h4000);
        step("R4 spl prev", 2, 16'o231, 0);
        step("R8 reload vs spl", 2, 16'o232, 0, 1, 16'h0000);
        step("R3 spl after kernel", 2, 16'o234, 0);
        step("R8 reload vs cc", 1, 16'o277, 0, 1, 16'h0012);
        step("R8 reload vs swab", 3, 0, 16'habcd, 1, 16'h3c00);
        for (int i = 0; i < 300; i++) begin
            int op, ins, opnd, rw;
            bit rv;
            op = $urandom_range(0, 3); ins = $urandom; opnd = $urandom;
            rw = $urandom; rv = ($urandom_range(0, 7) == 0);
            step("R2-9 mix", op, ins & 16'hffff, opnd & 16'hffff, rv, rw & 16'hffff);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule